// File: doc/BRIEF.md
# Framed serial command receiver

This block is the receiving end of a slave serial port. It takes a serial clock, a data line, an active-low select and a dual-purpose frame-sync pin. All four inputs are asynchronous to the block. A faster system clock oversamples them, so the serial clock is never used as a clock. Bits are shifted in MSB first on the active serial clock edge. When a frame ends validly, the block hands the most recent 16-bit command word to downstream logic together with a single-cycle strobe.

Once reset is released and the inputs have settled, the level of the frame-sync pin picks the active serial clock edge. It stays picked until the next reset. In select-framed operation, the word is released only when the select rises after a nonzero multiple of 16 bits. A rising edge on the frame-sync pin after that point moves the block for good into a frame-sync operation. In that operation, a falling frame-sync edge opens a frame, and the sixteenth bit commits the word without any select release.

Top module: `frame_cmd_rx`

## Requirements
- R1: After reset, `cmdValid` is 0 and `cmdWord` is 0.
- R2: The frame-sync level seen once the inputs have settled after reset chooses the active serial clock edge: high selects rising edges, low selects falling edges. The choice is held until the next reset.
- R3: Bits are shifted MSB first. The first bit of the word lands in bit 15 of `cmdWord`. Each accepted word is marked by `cmdValid` high for exactly one system clock cycle, and `cmdWord` holds that word until the next accepted word.
- R4: In select-framed operation, a falling select clears the bit count. A rising select releases the word only when the count since that fall is a nonzero multiple of 16.
- R5: A select rise after a bit count that is not a multiple of 16 produces no strobe and leaves `cmdWord` unchanged.
- R6: A select rise with zero bits received produces no strobe.
- R7: When more than 16 bits arrive in one select-low period (for example 32), only the last 16 bits are delivered, with one strobe.
- R8: The first rising frame-sync edge after the settle period switches the block permanently into frame-sync operation. In that operation, bits are shifted on falling serial clock edges, whatever edge was chosen at reset.
- R9: In frame-sync operation, a falling frame-sync edge with select low starts a frame. The sixteenth falling serial clock edge of that frame delivers the word, with select still low. Further edges before the next falling frame-sync edge deliver nothing.
- R10: In frame-sync operation, a frame opened while select is high delivers nothing. A select rise never delivers a word.
- R11: In select-framed operation, serial clock edges while select is high are not counted or shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the master |
| dataIn | input | 1 | Serial data |
| csN | input | 1 | Active-low select |
| fsyncIn | input | 1 | Edge-choice strap at reset; frame-sync pulse afterwards |
| cmdWord | output | 16 | Last accepted command word |
| cmdValid | output | 1 | One-cycle strobe marking a new `cmdWord` |

## Verification
The bench changes the data line between the rising and falling serial clock edges of every bit. The rising edge therefore captures one word and the falling edge another. A block that used the wrong edge, or kept the strapped edge after entering frame-sync operation, would deliver the other pattern. Aborted frames of 12 and 5 bits, an empty select pulse and clock toggling with select high catch a counter that is not cleared at the select fall, or that counts while deselected. Such a counter would drop the next valid word or release a bad one. A 32-bit frame shows whether the word is a true sliding window: a design that froze after 16 bits would return the older half. In frame-sync operation, the bench sends extra bits after the sixteenth, a select release, and a frame with select high. A design that still waited for the select rise, or that did not disarm after committing, would emit stray strobes.

// File: rtl/frx_pkg.sv
package frx_pkg;

  // Control -> datapath strobes
  typedef struct packed {
    logic shiftEn;
    logic clearCnt;
    logic commit;
  } frxStrobe_t;

  // Datapath -> control status
  typedef struct packed {
    logic csLow;
    logic csRise;
    logic csFall;
    logic fsLevel;
    logic fsRise;
    logic fsFall;
    logic sclkRise;
    logic sclkFall;
    logic cntWrap;
    logic anyBits;
    logic lastBit;
  } frxStatus_t;

endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= INIT;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign level = stage[STAGES-1];

endmodule

// File: rtl/frx_datapath.sv
module frx_datapath
  import frx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              dataIn,
  input  logic              csN,
  input  logic              fsyncIn,
  input  frxStrobe_t        strobe,
  output frxStatus_t        status,
  output logic [WORD_W-1:0] cmdWord,
  output logic              cmdValid
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam int PIN_SCLK = 0;
  localparam int PIN_DATA = 1;
  localparam int PIN_CS   = 2;
  localparam int PIN_FS   = 3;

  logic [3:0] pinLevel;
  logic [2:0] edgePrev;   // {fs, cs, sclk} one cycle back
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextShift;
  logic [CNT_W-1:0]  bitCnt;
  logic              anyBits;

  frx_sync #(
    .WIDTH (4),
    .STAGES(SYNC_STAGES),
    .INIT  (4'b0100)
  ) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({fsyncIn, csN, dataIn, sclkIn}),
    .level(pinLevel)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgePrev <= 3'b010;
    else       edgePrev <= {pinLevel[PIN_FS], pinLevel[PIN_CS], pinLevel[PIN_SCLK]};
  end

  always_comb begin
    status.csLow    = !pinLevel[PIN_CS];
    status.csRise   =  pinLevel[PIN_CS] && !edgePrev[1];
    status.csFall   = !pinLevel[PIN_CS] &&  edgePrev[1];
    status.fsLevel  =  pinLevel[PIN_FS];
    status.fsRise   =  pinLevel[PIN_FS] && !edgePrev[2];
    status.fsFall   = !pinLevel[PIN_FS] &&  edgePrev[2];
    status.sclkRise =  pinLevel[PIN_SCLK] && !edgePrev[0];
    status.sclkFall = !pinLevel[PIN_SCLK] &&  edgePrev[0];
    status.cntWrap  = (bitCnt == '0);
    status.anyBits  = anyBits;
    status.lastBit  = (bitCnt == LAST);
  end

  assign nextShift = {shiftReg[WORD_W-2:0], pinLevel[PIN_DATA]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      anyBits  <= 1'b0;
      cmdWord  <= '0;
      cmdValid <= 1'b0;
    end else begin
      if (strobe.clearCnt) begin
        bitCnt  <= '0;
        anyBits <= 1'b0;
      end else if (strobe.shiftEn) begin
        bitCnt  <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
        anyBits <= 1'b1;
      end
      if (strobe.shiftEn) shiftReg <= nextShift;
      cmdValid <= strobe.commit;
      if (strobe.commit) cmdWord <= strobe.shiftEn ? nextShift : shiftReg;
    end
  end

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(cmdWord));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_count_cleared_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCnt |=> (bitCnt == '0) && !anyBits);

endmodule

// File: rtl/frx_control.sv
module frx_control
  import frx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  frxStatus_t status,
  output frxStrobe_t strobe
);

  localparam int SETTLE = SYNC_STAGES + 2;
  localparam int SET_W  = $clog2(SETTLE + 1);

  logic [SET_W-1:0] settleCnt;
  logic settled;
  logic activeRise;
  logic fsMode;
  logic armed;
  logic activeEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt  <= '0;
      settled    <= 1'b0;
      activeRise <= 1'b0;
      fsMode     <= 1'b0;
      armed      <= 1'b0;
    end else if (!settled) begin
      if (settleCnt == SET_W'(SETTLE - 1)) begin
        settled    <= 1'b1;
        activeRise <= status.fsLevel;
      end else begin
        settleCnt <= settleCnt + 1'b1;
      end
    end else if (!fsMode) begin
      if (status.fsRise) fsMode <= 1'b1;
      armed <= 1'b0;
    end else begin
      if (!status.csLow || strobe.commit) armed <= 1'b0;
      else if (status.fsFall)             armed <= 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    if (fsMode)          activeEdge = status.sclkFall;
    else if (activeRise) activeEdge = status.sclkRise;
    else                 activeEdge = status.sclkFall;

    if (settled && !fsMode) begin
      strobe.clearCnt = status.csFall;
      strobe.shiftEn  = status.csLow && activeEdge && !status.csFall;
      strobe.commit   = status.csRise && status.cntWrap && status.anyBits;
    end else if (fsMode) begin
      strobe.clearCnt = status.fsFall && status.csLow;
      strobe.shiftEn  = armed && status.csLow && activeEdge && !status.fsFall;
      strobe.commit   = strobe.shiftEn && status.lastBit;
    end
  end

  assert_fsmode_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    fsMode |=> fsMode);

  assert_edge_choice_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    settled |=> $stable(activeRise));

  assert_no_release_commit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fsMode && status.csRise) |-> !strobe.commit);

endmodule

// File: rtl/frame_cmd_rx.sv
module frame_cmd_rx
  import frx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              dataIn,
  input  logic              csN,
  input  logic              fsyncIn,
  output logic [WORD_W-1:0] cmdWord,
  output logic              cmdValid
);

  frxStrobe_t strobe;
  frxStatus_t status;

  frx_control #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_control (
    .clk   (clk),
    .rstN  (rstN),
    .status(status),
    .strobe(strobe)
  );

  frx_datapath #(
    .WORD_W     (WORD_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .sclkIn  (sclkIn),
    .dataIn  (dataIn),
    .csN     (csN),
    .fsyncIn (fsyncIn),
    .strobe  (strobe),
    .status  (status),
    .cmdWord (cmdWord),
    .cmdValid(cmdValid)
  );

endmodule

// File: tb/test_frame_cmd_rx.sv
module test_frame_cmd_rx;

  logic clk = 1'b0;
  logic rstN, sclk, din, csN, fsync;
  logic [15:0] cmdWord;
  logic cmdValid;
  int checks = 0;
  int fails = 0;
  int pulses = 0;
  logic [15:0] lastWord = '0;

  always #10 clk = ~clk;  // 50 MHz

  frame_cmd_rx i_frame_cmd_rx (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .dataIn(din), .csN(csN),
    .fsyncIn(fsync), .cmdWord(cmdWord), .cmdValid(cmdValid)
  );

  always @(negedge clk) if (rstN && cmdValid) begin
    pulses++;
    lastWord = cmdWord;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic fsLvl);
    rstN = 1'b0; sclk = 1'b0; din = 1'b0; csN = 1'b1; fsync = fsLvl;
    idle(5);
    rstN = 1'b1;
    idle(10);
  endtask

  // Each bit: data wr[i] held across the rising edge, wf[i] across the falling edge
  task automatic clkBits(input logic [31:0] wr, input logic [31:0] wf, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      din = wr[i]; idle(4);
      sclk = 1'b1; idle(2);
      din = wf[i]; idle(2);
      sclk = 1'b0; idle(4);
    end
  endtask

  task automatic frame(input logic [31:0] wr, input logic [31:0] wf, input int n);
    csN = 1'b0; idle(4);
    clkBits(wr, wf, n);
    csN = 1'b1; idle(8);
  endtask

  task automatic testReset();
    doReset(1'b1);
    check(cmdValid == 1'b0, "R1", "cmdValid after reset", 32'(cmdValid), 0);
    check(cmdWord == 16'h0, "R1", "cmdWord after reset", 32'(cmdWord), 0);
  endtask

  task automatic testRiseEdge();
    int p0 = pulses;
    frame(32'hA5C3, 32'h1234, 16);
    check(pulses == p0 + 1, "R3", "one strobe per word", 32'(pulses - p0), 1);
    check(lastWord == 16'hA5C3, "R2", "rising edge capture", 32'(lastWord), 32'hA5C3);
  endtask

  task automatic testFallEdge();
    int p0;
    doReset(1'b0);
    p0 = pulses;
    frame(32'hA5C3, 32'h1234, 16);
    check(pulses == p0 + 1, "R3", "strobe count falling mode", 32'(pulses - p0), 1);
    check(lastWord == 16'h1234, "R2", "falling edge capture", 32'(lastWord), 32'h1234);
  endtask

  task automatic testPartial();
    int p0 = pulses;
    frame(32'hFFF, 32'hFFF, 12);
    check(pulses == p0, "R5", "12-bit frame strobes", 32'(pulses - p0), 0);
    check(cmdWord == 16'h1234, "R5", "word after short frame", 32'(cmdWord), 32'h1234);
  endtask

  task automatic testEmpty();
    int p0 = pulses;
    csN = 1'b0; idle(8); csN = 1'b1; idle(8);
    check(pulses == p0, "R6", "empty frame strobes", 32'(pulses - p0), 0);
  endtask

  task automatic testRestart();
    int p0 = pulses;
    frame(32'h1F, 32'h1F, 5);
    frame(32'h0F0F, 32'h0F0F, 16);
    check(pulses == p0 + 1, "R4", "count cleared at select fall", 32'(pulses - p0), 1);
    check(lastWord == 16'h0F0F, "R4", "word after aborted frame", 32'(lastWord), 32'h0F0F);
  endtask

  task automatic testIdleClock();
    int p0 = pulses;
    clkBits(32'h7, 32'h7, 3);  // select high
    idle(8);
    frame(32'h8001, 32'h8001, 16);
    check(pulses == p0 + 1, "R11", "strobes after idle clocks", 32'(pulses - p0), 1);
    check(lastWord == 16'h8001, "R11", "idle clocks not shifted", 32'(lastWord), 32'h8001);
  endtask

  task automatic testLong();
    int p0 = pulses;
    frame(32'hDEADBEEF, 32'hDEADBEEF, 32);
    check(pulses == p0 + 1, "R7", "one strobe for 32 bits", 32'(pulses - p0), 1);
    check(lastWord == 16'hBEEF, "R7", "last 16 bits kept", 32'(lastWord), 32'hBEEF);
  endtask

  task automatic testFsMode();
    int p0;
    doReset(1'b1);          // strapped to rising edges
    fsync = 1'b0; idle(8);  // fall in select-framed operation: no effect
    fsync = 1'b1; idle(8);  // enter frame-sync operation
    p0 = pulses;
    csN = 1'b0; idle(4);
    fsync = 1'b0; idle(4);
    clkBits(32'h3333, 32'hC3A5, 16);
    idle(6);
    check(pulses == p0 + 1, "R9", "commit without select rise", 32'(pulses - p0), 1);
    check(csN == 1'b0, "R9", "select still low at commit", 32'(csN), 0);
    check(lastWord == 16'hC3A5, "R8", "falling edge in frame-sync", 32'(lastWord), 32'hC3A5);
    clkBits(32'h1F, 32'h1F, 5);
    idle(6);
    check(pulses == p0 + 1, "R9", "extra bits after commit", 32'(pulses - p0), 1);
    csN = 1'b1; idle(8);
    check(pulses == p0 + 1, "R10", "select rise commits nothing", 32'(pulses - p0), 1);
    fsync = 1'b1; idle(4); fsync = 1'b0; idle(4);
    clkBits(32'h6666, 32'h6666, 16);
    idle(6);
    check(pulses == p0 + 1, "R10", "frame with select high", 32'(pulses - p0), 1);
    check(cmdWord == 16'hC3A5, "R10", "word kept with select high", 32'(cmdWord), 32'hC3A5);
    csN = 1'b0; idle(4);
    fsync = 1'b1; idle(4); fsync = 1'b0; idle(4);
    clkBits(32'h0000, 32'h5AF0, 16);
    idle(6);
    check(pulses == p0 + 2, "R8", "frame-sync operation persists", 32'(pulses - p0), 2);
    check(lastWord == 16'h5AF0, "R8", "second frame-sync word", 32'(lastWord), 32'h5AF0);
    csN = 1'b1; idle(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testRiseEdge();
    testFallEdge();
    testPartial();
    testEmpty();
    testRestart();
    testIdleClock();
    testLong();
    testFsMode();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule